// File: doc/BRIEF.md
# Boundary-Pausing System DMA Engine

This block is the single-address DMA mover inside an SD host controller. Software programs a 32-bit system address, a block byte count with a boundary code, a block count, a transfer-mode word and the host-control DMA-kind field through one register write port. A start write then launches the transfer. The engine moves 32-bit beats between the card-side data buffer and a simple memory port. In the card-to-host direction it pops the buffer and writes memory. In the host-to-card direction it reads memory and pushes the buffer.

The engine watches the running address. When the address lands on the programmed power-of-two boundary, the engine parks and raises the DMA-boundary interrupt flag. Software restarts it by writing a fresh system address. When the final block has moved, the engine raises transfer-complete. A data error aborts the transfer. Interrupt flags are write-1-to-clear.

Top module: `sdma_engine`

## Requirements
- R1: After reset, `int_status`, `sys_addr` and `blk_count` are zero and `mem_req` is low.
- R2: A start write (selector 5) launches a transfer only under all of these conditions: the engine is idle, mode bit 0 (DMA enable) is 1, host-control bits [4:3] are 00, and the block byte count is non-zero. When mode bits 5 and 1 are both set, the block count must also be non-zero. Any other start write is ignored.
- R3: Each accepted beat (`mem_req` and `mem_ready` both high) moves 4 bytes at `mem_addr` = `sys_addr`, and `sys_addr` then advances by 4. With mode bit 4 = 1 (card to host), `mem_we` is 1 and `mem_wdata` carries `buf_rd_data`. With bit 4 = 0, `mem_we` is 0 and `buf_wr_data` carries `mem_rdata`.
- R4: Block-size register (selector 1): bits [11:0] give the block length in bytes, moved as ceil(len/4) beats. Bits [14:12] give a code n that selects a boundary of 4096 << n bytes.
- R5: When the address after a beat is a multiple of the boundary and the transfer is not finished, the engine parks. It sets `int_status` bit 3 and keeps `mem_req` low.
- R6: While parked, a write to selector 0 loads that address and resumes the remaining transfer from it. While the engine is busy, writes to selectors 0 to 5 are otherwise ignored.
- R7: With mode bits 5 and 1 both set, `blk_count` drops by one after every block. The transfer completes when it reaches zero, and `int_status` bit 1 is then set.
- R8: With mode bit 5 clear, exactly one block moves, then bit 1 is set and `blk_count` is unchanged.
- R9: If the last beat ends exactly on a boundary, only bit 1 is set, not bit 3.
- R10: A write to selector 6 clears every `int_status` bit written as 1 and leaves the bits written as 0 unchanged.
- R11: `data_err` during a transfer stops it at once, sets bit 15, and does not set bit 1.
- R12: On completion with mode bits 5 and 2 set, `auto_stop` pulses high for one cycle, aligned with bit 1 rising. Otherwise it stays low.
- R13: With mode bit 5 set and bit 1 clear, blocks keep moving past every block end and `blk_count` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register selector: 0 address, 1 block size, 2 block count, 3 mode, 4 host control, 5 start, 6 status clear |
| reg_wr_data | input | 32 | Register write data |
| data_err | input | 1 | Data error from the card side |
| buf_rd_valid | input | 1 | Card buffer holds a word for memory |
| buf_rd_data | input | 32 | Word from card buffer |
| buf_rd_ready | output | 1 | Card buffer word taken |
| buf_wr_valid | output | 1 | Word pushed to card buffer |
| buf_wr_data | output | 32 | Word for card buffer |
| buf_wr_ready | input | 1 | Card buffer can take a word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid in the accepting cycle |
| int_status | output | 16 | Interrupt flags: bit 1 done, bit 3 boundary, bit 15 error |
| sys_addr | output | 32 | Running system address |
| blk_count | output | 16 | Remaining block count |
| card_to_host | output | 1 | Decoded transfer direction |
| auto_stop | output | 1 | One-cycle request for an automatic stop command |

## Verification
The assertions assume a few things about the block's inputs. `data_err` counts only while a transfer is running or parked. `mem_ready` does not depend combinationally on `mem_req`. Software never reprograms block size or mode between a start and its completion. The assertions also rely on the fact that a new start cannot follow a completion in the very next cycle. The stimulus drives every input one time unit after the rising edge and issues register writes only from the write task, one per cycle. It starts transfers only at aligned word addresses and issues `data_err` only while a transfer is active. It throttles `mem_ready` with a fixed repeating pattern that never looks at `mem_req`.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int ADDR_W        = 32;
    localparam int WORD_W        = 32;
    localparam int BEAT_BYTES    = WORD_W / 8;
    localparam int STS_W         = 16;
    localparam int STS_DONE      = 1;
    localparam int STS_BND       = 3;
    localparam int STS_ERR       = 15;
    localparam int BND_W         = 3;
    localparam int BND_BASE_LOG2 = 12;
    localparam int KIND_W        = 2;
    localparam logic [KIND_W-1:0] KIND_SDMA = 2'b00;

    typedef enum logic [2:0] {
        SEL_ADDR  = 3'd0,
        SEL_BSIZE = 3'd1,
        SEL_BCNT  = 3'd2,
        SEL_MODE  = 3'd3,
        SEL_HCTL  = 3'd4,
        SEL_GO    = 3'd5,
        SEL_ICLR  = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic multi;
        logic card_to_host;
        logic auto_stop;
        logic cnt_en;
        logic dma_en;
    } xfer_mode_t;

    function automatic logic on_boundary(input logic [ADDR_W-1:0] a,
                                         input logic [BND_W-1:0]  code);
        logic [ADDR_W-1:0] mask;
        mask = (ADDR_W'(1) << (BND_BASE_LOG2 + int'(code))) - ADDR_W'(1);
        return (a & mask) == '0;
    endfunction

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int SIZE_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_sel_e             wr_sel,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 idle,
    output logic [SIZE_W-1:0]    blk_bytes,
    output logic [BND_W-1:0]     bnd_code,
    output xfer_mode_t           mode,
    output logic [KIND_W-1:0]    dma_kind,
    output logic                 go
);

    localparam int CODE_LSB = SIZE_W;
    localparam int USED_TOP = SIZE_W + BND_W;

    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data[WORD_W-1:USED_TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_bytes <= '0;
            bnd_code  <= '0;
            mode      <= '0;
            dma_kind  <= '0;
        end else if (wr_en && idle) begin
            case (wr_sel)
                SEL_BSIZE: begin
                    blk_bytes <= wr_data[SIZE_W-1:0];
                    bnd_code  <= wr_data[CODE_LSB +: BND_W];
                end
                SEL_MODE: begin
                    mode.dma_en       <= wr_data[0];
                    mode.cnt_en       <= wr_data[1];
                    mode.auto_stop    <= wr_data[2];
                    mode.card_to_host <= wr_data[4];
                    mode.multi        <= wr_data[5];
                end
                SEL_HCTL: dma_kind <= wr_data[4:3];
                default: ;
            endcase
        end
    end

    assign go = wr_en && idle && (wr_sel == SEL_GO);

    // configuration cannot move while a transfer owns it
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        !idle |=> ($stable(blk_bytes) && $stable(bnd_code) &&
                   $stable(mode) && $stable(dma_kind)))
        else $error("config changed while busy");

endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
    import sdma_pkg::*;
(
    input  logic              run,
    input  logic              card_to_host,
    input  logic              buf_rd_valid,
    input  logic [WORD_W-1:0] buf_rd_data,
    output logic              buf_rd_ready,
    output logic              buf_wr_valid,
    output logic [WORD_W-1:0] buf_wr_data,
    input  logic              buf_wr_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              fire
);

    logic src_avail;

    always_comb begin
        src_avail    = card_to_host ? buf_rd_valid : buf_wr_ready;
        mem_req      = run && src_avail;
        mem_we       = card_to_host;
        mem_wdata    = buf_rd_data;
        fire         = mem_req && mem_ready;
        buf_rd_ready = fire && card_to_host;
        buf_wr_valid = fire && !card_to_host;
        buf_wr_data  = mem_rdata;
    end

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
    import sdma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [SIZE_W-1:0]    blk_bytes,
    input  logic [BND_W-1:0]     bnd_code,
    input  xfer_mode_t           mode,
    input  logic [KIND_W-1:0]    dma_kind,
    input  logic                 addr_wr,
    input  logic                 cnt_wr,
    input  logic                 clr_wr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 fire,
    input  logic                 data_err,
    output eng_state_e           state,
    output logic [ADDR_W-1:0]    sys_addr,
    output logic [CNT_W-1:0]     blk_count,
    output logic [STS_W-1:0]     int_status,
    output logic                 auto_stop
);

    localparam logic [SIZE_W-1:0] BEAT_SZ = SIZE_W'(BEAT_BYTES);

    logic [SIZE_W-1:0]  rem, rem_n;
    eng_state_e         state_n;
    logic [ADDR_W-1:0]  addr_n, addr_step;
    logic [CNT_W-1:0]   cnt_n;
    logic [STS_W-1:0]   set_m, clr_m;
    logic               auto_n, start_ok, block_end, last_block, counted;

    logic unused_mode;
    assign unused_mode = mode.card_to_host;

    assign counted    = mode.multi && mode.cnt_en;
    assign start_ok   = go && mode.dma_en && (dma_kind == KIND_SDMA) &&
                        (blk_bytes != '0) && !(counted && blk_count == '0);
    assign block_end  = rem <= BEAT_SZ;
    assign last_block = !mode.multi || (mode.cnt_en && blk_count == CNT_W'(1));
    assign addr_step  = sys_addr + ADDR_W'(BEAT_BYTES);
    assign clr_m      = clr_wr ? wr_data[STS_W-1:0] : '0;

    always_comb begin
        state_n = state;
        addr_n  = sys_addr;
        cnt_n   = blk_count;
        rem_n   = rem;
        set_m   = '0;
        auto_n  = 1'b0;
        if (data_err && state != ST_IDLE) begin
            state_n        = ST_IDLE;
            set_m[STS_ERR] = 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (addr_wr) addr_n = wr_data[ADDR_W-1:0];
                    if (cnt_wr)  cnt_n  = wr_data[CNT_W-1:0];
                    if (start_ok) begin
                        state_n = ST_RUN;
                        rem_n   = blk_bytes;
                    end
                end
                ST_RUN: begin
                    if (fire) begin
                        addr_n = addr_step;
                        if (block_end) begin
                            rem_n = blk_bytes;
                            if (counted) cnt_n = blk_count - CNT_W'(1);
                        end else begin
                            rem_n = rem - BEAT_SZ;
                        end
                        if (block_end && last_block) begin
                            state_n         = ST_IDLE;
                            set_m[STS_DONE] = 1'b1;
                            auto_n          = mode.multi && mode.auto_stop;
                        end else if (on_boundary(addr_step, bnd_code)) begin
                            state_n        = ST_HOLD;
                            set_m[STS_BND] = 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (addr_wr) begin
                        addr_n  = wr_data[ADDR_W-1:0];
                        state_n = ST_RUN;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sys_addr   <= '0;
            blk_count  <= '0;
            rem        <= '0;
            int_status <= '0;
            auto_stop  <= 1'b0;
        end else begin
            state      <= state_n;
            sys_addr   <= addr_n;
            blk_count  <= cnt_n;
            rem        <= rem_n;
            int_status <= (int_status & ~clr_m) | set_m;
            auto_stop  <= auto_n;
        end
    end

    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !fire)
        else $error("beat moved while parked");

    p_bnd_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state) == ST_RUN) |-> int_status[STS_BND])
        else $error("parked without boundary flag");

    p_fire_in_run_r3: assert property (@(posedge clk) disable iff (rst)
        fire |-> (state == ST_RUN))
        else $error("beat outside run state");

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && fire && !data_err) |=>
            (sys_addr == $past(sys_addr) + ADDR_W'(BEAT_BYTES)))
        else $error("address did not step by one beat");

    p_err_stop_r11: assert property (@(posedge clk) disable iff (rst)
        (data_err && state != ST_IDLE) |=> (state == ST_IDLE && int_status[STS_ERR]))
        else $error("error did not stop the engine");

    p_single_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !mode.multi) |=> $stable(blk_count))
        else $error("single-block transfer touched the count");

    p_auto_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        auto_stop |=> !auto_stop)
        else $error("auto-stop longer than one cycle");

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr_en,
    input  logic [2:0]          reg_wr_sel,
    input  logic [WORD_W-1:0]   reg_wr_data,
    input  logic                data_err,
    input  logic                buf_rd_valid,
    input  logic [WORD_W-1:0]   buf_rd_data,
    output logic                buf_rd_ready,
    output logic                buf_wr_valid,
    output logic [WORD_W-1:0]   buf_wr_data,
    input  logic                buf_wr_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic [STS_W-1:0]    int_status,
    output logic [ADDR_W-1:0]   sys_addr,
    output logic [CNT_W-1:0]    blk_count,
    output logic                card_to_host,
    output logic                auto_stop
);

    reg_sel_e           sel;
    eng_state_e         state;
    logic [SIZE_W-1:0]  blk_bytes;
    logic [BND_W-1:0]   bnd_code;
    xfer_mode_t         mode;
    logic [KIND_W-1:0]  dma_kind;
    logic               go, fire, idle;

    assign sel          = reg_sel_e'(reg_wr_sel);
    assign idle         = (state == ST_IDLE);
    assign mem_addr     = sys_addr;
    assign card_to_host = mode.card_to_host;

    sdma_regs #(.SIZE_W(SIZE_W)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_sel    (sel),
        .wr_data   (reg_wr_data),
        .idle      (idle),
        .blk_bytes (blk_bytes),
        .bnd_code  (bnd_code),
        .mode      (mode),
        .dma_kind  (dma_kind),
        .go        (go)
    );

    sdma_mover i_mover (
        .run          (state == ST_RUN),
        .card_to_host (mode.card_to_host),
        .buf_rd_valid (buf_rd_valid),
        .buf_rd_data  (buf_rd_data),
        .buf_rd_ready (buf_rd_ready),
        .buf_wr_valid (buf_wr_valid),
        .buf_wr_data  (buf_wr_data),
        .buf_wr_ready (buf_wr_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .fire         (fire)
    );

    sdma_ctrl #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .blk_bytes  (blk_bytes),
        .bnd_code   (bnd_code),
        .mode       (mode),
        .dma_kind   (dma_kind),
        .addr_wr    (reg_wr_en && sel == SEL_ADDR),
        .cnt_wr     (reg_wr_en && sel == SEL_BCNT),
        .clr_wr     (reg_wr_en && sel == SEL_ICLR),
        .wr_data    (reg_wr_data),
        .fire       (fire),
        .data_err   (data_err),
        .state      (state),
        .sys_addr   (sys_addr),
        .blk_count  (blk_count),
        .int_status (int_status),
        .auto_stop  (auto_stop)
    );

endmodule

// File: tb/test_sdma_engine.sv
module test_sdma_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic        data_err = 1'b0;
    logic        buf_rd_valid = 1'b0;
    logic [31:0] buf_rd_data = '0;
    logic        buf_rd_ready, buf_wr_valid;
    logic [31:0] buf_wr_data;
    logic        buf_wr_ready = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata;
    logic [15:0] int_status;
    logic [31:0] sys_addr;
    logic [15:0] blk_count;
    logic        card_to_host, auto_stop;

    assign mem_rdata = ~mem_addr;

    sdma_engine i_sdma_engine (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .data_err(data_err),
        .buf_rd_valid(buf_rd_valid), .buf_rd_data(buf_rd_data), .buf_rd_ready(buf_rd_ready),
        .buf_wr_valid(buf_wr_valid), .buf_wr_data(buf_wr_data), .buf_wr_ready(buf_wr_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .int_status(int_status),
        .sys_addr(sys_addr), .blk_count(blk_count), .card_to_host(card_to_host),
        .auto_stop(auto_stop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int pat = 0;
    int auto_seen = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_state, m_rem, m_size, m_code, m_cnt;
    logic [31:0] m_addr;
    logic [5:0]  m_mode;
    logic [1:0]  m_kind;
    logic [15:0] m_sts;
    logic        m_auto;

    function automatic bit m_bnd(input logic [31:0] a, input int code);
        return (a & ((32'h1000 << code) - 1)) == 0;
    endfunction

    always @(posedge clk) begin
        int s0;
        bit go_fire, last;
        logic [15:0] setv;
        if (rst) begin
            m_state = 0; m_rem = 0; m_size = 0; m_code = 0; m_cnt = 0;
            m_addr = 0; m_mode = 0; m_kind = 0; m_sts = 0; m_auto = 0;
        end else begin
            s0 = m_state;
            setv = 0;
            m_auto = 0;
            go_fire = (s0 == 1) && (m_mode[4] ? buf_rd_valid : buf_wr_ready) && mem_ready;
            if (data_err && s0 != 0) begin
                m_state = 0; setv[15] = 1;
            end else if (go_fire) begin
                m_addr = m_addr + 4;
                if (m_rem <= 4) begin
                    last = !m_mode[5] || (m_mode[1] && m_cnt == 1);
                    m_rem = m_size;
                    if (m_mode[5] && m_mode[1]) m_cnt = m_cnt - 1;
                    if (last) begin
                        m_state = 0; setv[1] = 1; m_auto = m_mode[5] && m_mode[2];
                    end else if (m_bnd(m_addr, m_code)) begin
                        m_state = 2; setv[3] = 1;
                    end
                end else begin
                    m_rem = m_rem - 4;
                    if (m_bnd(m_addr, m_code)) begin m_state = 2; setv[3] = 1; end
                end
            end
            if (reg_wr_en) begin
                case (reg_wr_sel)
                    3'd0: if (s0 == 0) m_addr = reg_wr_data;
                          else if (s0 == 2 && !data_err) begin m_addr = reg_wr_data; m_state = 1; end
                    3'd1: if (s0 == 0) begin m_size = int'(reg_wr_data[11:0]); m_code = int'(reg_wr_data[14:12]); end
                    3'd2: if (s0 == 0) m_cnt = int'(reg_wr_data[15:0]);
                    3'd3: if (s0 == 0) m_mode = {reg_wr_data[5:4], 1'b0, reg_wr_data[2:0]};
                    3'd4: if (s0 == 0) m_kind = reg_wr_data[4:3];
                    3'd5: if (s0 == 0 && m_mode[0] && m_kind == 0 && m_size != 0 &&
                              !(m_mode[5] && m_mode[1] && m_cnt == 0)) begin
                              m_state = 1; m_rem = m_size;
                          end
                    3'd6: m_sts = m_sts & ~reg_wr_data[15:0];
                    default: ;
                endcase
            end
            m_sts = m_sts | setv;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit exp_req;
        if (!rst) begin
            exp_req = (m_state == 1) && (m_mode[4] ? buf_rd_valid : buf_wr_ready);
            chk("R10 int_status", {16'h0, int_status}, {16'h0, m_sts});
            chk("R3 sys_addr", sys_addr, m_addr);
            chk("R7 blk_count", {16'h0, blk_count}, m_cnt & 32'hFFFF);
            chk("R5 mem_req", {31'h0, mem_req}, {31'h0, exp_req});
            chk("R12 auto_stop", {31'h0, auto_stop}, {31'h0, m_auto});
            if (auto_stop) auto_seen++;
            if (exp_req) begin
                chk("R3 mem_addr", mem_addr, m_addr);
                chk("R3 mem_we", {31'h0, mem_we}, {31'h0, m_mode[4]});
                if (m_mode[4]) chk("R3 mem_wdata", mem_wdata, buf_rd_data);
                else if (mem_ready) chk("R3 buf_wr_data", buf_wr_data, ~m_addr);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            cyc++;
            mem_ready   = (pat == 0) ? 1'b1 : (cyc % 3 != 2);
            buf_rd_data = 32'hA5000000 + cyc;
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = 3'(sel); reg_wr_data = d;
        step(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_flag(input logic [15:0] mask);
        for (int k = 0; k < 2000 && (int_status & mask) == 0; k++) step(1);
    endtask

    initial begin
        int base;
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        step(3);
        rst = 1'b0;
        chk("R1 status", {16'h0, int_status}, 0);
        chk("R1 addr", sys_addr, 0);
        chk("R1 count", {16'h0, blk_count}, 0);
        chk("R1 req", {31'h0, mem_req}, 0);

        // R2: starts that must be ignored
        buf_wr_ready = 1'b1; buf_rd_valid = 1'b1;
        wr(0, 32'h100); wr(1, 32'h0000_000A); wr(2, 5);
        wr(3, 32'h00); wr(5, 0); step(3);
        chk("R2 no dma enable", {31'h0, mem_req}, 0);
        wr(3, 32'h13); wr(4, 32'h10); wr(5, 0); step(3);
        chk("R2 adma kind", {31'h0, mem_req}, 0);
        wr(4, 32'h00); wr(3, 32'h23); wr(2, 0); wr(5, 0); step(3);
        chk("R2 zero count", {31'h0, mem_req}, 0);
        chk("R2 addr kept", sys_addr, 32'h100);

        // R8/R4: single read block of 10 bytes -> 3 beats
        wr(2, 5); wr(3, 32'h13); wr(5, 0);
        wait_flag(16'h0002); step(1);
        chk("R4 beats rounded", sys_addr, 32'h10C);
        chk("R8 count kept", {16'h0, blk_count}, 5);
        chk("R8 done flag", {16'h0, int_status}, 32'h2);

        // R10: write one to clear
        wr(6, 32'h0008); step(1);
        chk("R10 zero bits kept", {16'h0, int_status}, 32'h2);
        wr(6, 32'h0002); step(1);
        chk("R10 cleared", {16'h0, int_status}, 0);

        // R5/R6/R7: host-to-card, counted multi-block, pause at 4 KiB
        pat = 1;
        wr(3, 32'h23); wr(2, 3); wr(1, 32'h0010); wr(0, 32'hFF8); wr(5, 0);
        wait_flag(16'h0008); step(1);
        chk("R5 parked addr", sys_addr, 32'h1000);
        chk("R5 bnd flag", {16'h0, int_status}, 32'h8);
        step(4);
        chk("R5 quiet while parked", {31'h0, mem_req}, 0);
        wr(1, 32'h0004); wr(3, 32'h13);
        chk("R6 mode write ignored", {31'h0, card_to_host}, 0);
        wr(6, 32'h8); wr(0, 32'h2000);
        wait_flag(16'h0002); step(1);
        chk("R6 resumed end addr", sys_addr, 32'h2028);
        chk("R7 count to zero", {16'h0, blk_count}, 0);
        chk("R7 done flag", {16'h0, int_status}, 32'h2);
        wr(6, 32'hFFFF);

        // R9: last beat lands on boundary
        pat = 0;
        wr(3, 32'h01); wr(1, 32'h0010); wr(0, 32'hFF0); wr(5, 0);
        wait_flag(16'h000A); step(2);
        chk("R9 only done", {16'h0, int_status}, 32'h2);
        chk("R9 end addr", sys_addr, 32'h1000);
        chk("R12 no pulse single", auto_seen, 0);
        wr(6, 32'hFFFF);

        // R12: auto-stop pulse on counted multi completion
        base = auto_seen;
        wr(3, 32'h27); wr(2, 2); wr(1, 32'h0004); wr(0, 32'h3000); wr(5, 0);
        wait_flag(16'h0002); step(2);
        chk("R12 one pulse", auto_seen - base, 1);
        wr(6, 32'hFFFF);

        // R13/R11: uncounted multi-block, then data error
        pat = 1;
        wr(3, 32'h31); wr(2, 9); wr(1, 32'h7008); wr(0, 32'h4000); wr(5, 0);
        step(30);
        chk("R13 count unchanged", {16'h0, blk_count}, 9);
        chk("R13 still running", {31'h0, mem_req}, 1);
        chk("R13 no flags", {16'h0, int_status}, 0);
        data_err = 1'b1; step(1); data_err = 1'b0; step(1);
        chk("R11 error flag only", {16'h0, int_status}, 32'h8000);
        chk("R11 stopped", {31'h0, mem_req}, 0);
        wr(6, 32'hFFFF);

        // R4: code 1 gives an 8 KiB boundary
        pat = 0;
        wr(3, 32'h11); wr(1, 32'h1020); wr(0, 32'h1FF0); wr(5, 0);
        wait_flag(16'h0008); step(1);
        chk("R4 8k park", sys_addr, 32'h2000);
        wr(6, 32'h8); wr(0, 32'h5000);
        wait_flag(16'h0002); step(1);
        chk("R6 resume address", sys_addr, 32'h5010);
        chk("R4 done", {16'h0, int_status}, 32'h2);

        step(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule